// File: doc/BRIEF.md
# Fully Associative Branch-Target Code Cache

This block is a small, fully associative code cache that sits between the fetch port of an 8-bit processor and a slow program memory. Each of its 63 slots holds one aligned four-byte word of code, the upper address bits of that word as a tag, and a valid flag. Every request address is compared against all valid tags at once. On a match, the addressed byte comes back in the same cycle, so the processor does not stall.

When no valid tag matches, the block raises its miss output. The fetch engine then fetches the word from program memory. It presents that word on the refill input while it holds the same request address. When caching is enabled, the word is written into a slot. If the tag is already present, that slot is updated in place. Otherwise the lowest-numbered empty slot is used, or the slot named by a round-robin pointer when no slot is empty. A flush input empties the whole cache in one cycle.

Top module: `tgt_cache`

## Requirements
- R1: After reset, no slot is valid, so every request reports hit=0 and miss=1.
- R2: On a hit, rdByte returns the cached byte chosen by reqAddr[1:0] in the same cycle. Byte k of a word is refillWord[8k+7:8k]. When hit is low, rdByte is 0.
- R3: When reqValid is high and no valid slot holds tag reqAddr[16:2], miss is high and hit is low. A request to a different four-byte block never hits on another block's slot.
- R4: A refill strobe with cacheEn=1 stores refillWord under the tag reqAddr[16:2]. From the next cycle on, all four byte addresses of that block hit. refillAck is high in the cycle after every refill strobe.
- R5: A refill with cacheEn=0 is acknowledged but writes nothing. The block stays a miss, and the slots already cached keep their contents.
- R6: New tags go to the lowest-numbered empty slot first. 63 distinct blocks refilled after a flush are all resident together.
- R7: When all slots are valid, the victim is the slot named by a round-robin pointer. The pointer advances after each new allocation and wraps from 62 back to 0, so the oldest block is evicted first.
- R8: A flush empties every slot in one cycle and returns the pointer to 0. A refill in the same cycle as a flush is not stored.
- R9: A refill whose tag is already valid rewrites that slot in place. No second slot with the same tag is ever created, and later reads return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A fetch request is present |
| reqAddr | input | 17 | Byte address of the request; it also gives the tag during a refill |
| cacheEn | input | 1 | Allows refilled words to be stored |
| flush | input | 1 | Empties every slot |
| refillValid | input | 1 | refillWord holds the memory word for reqAddr's block |
| refillWord | input | 32 | Four code bytes, with byte 0 in bits 7:0 |
| hit | output | 1 | Request matched a valid slot |
| miss | output | 1 | Request matched no valid slot |
| rdByte | output | 8 | Addressed byte on a hit, else 0 |
| refillAck | output | 1 | Refill strobe accepted, one cycle later |

## Verification
Some properties are checked on every cycle. At most one slot matches any address, the replacement pointer stays in range and wraps from 62 to 0, a flush leaves no valid slot one cycle later, no slot becomes valid while caching is disabled, and every refill is acknowledged on the next cycle. Other behaviour is shown only by the bench's scenarios. These cover the byte order on a hit, the empty-slot-first fill order, the eviction of the oldest block once the cache is full, in-place rewrite of a duplicate tag, and a flush taking priority over a refill in the same cycle.

// File: rtl/tgt_cache_pkg.sv
`timescale 1ns/1ps
package tgt_cache_pkg;
  // Strobes from the control unit to the storage datapath
  typedef struct packed {
    logic wrEn;      // write refill word into slot wrIdx
    logic flushAll;  // clear every valid flag
  } ctrl_strb_t;
endpackage

// File: rtl/tgt_cache_dp.sv
`timescale 1ns/1ps
module tgt_cache_dp
  import tgt_cache_pkg::*;
#(
  parameter int SLOTS  = 63,
  parameter int ADDR_W = 17,
  parameter int BYTES  = 4,
  localparam int OFFS_W = $clog2(BYTES),
  localparam int TAG_W  = ADDR_W - OFFS_W,
  localparam int WORD_W = 8 * BYTES,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] refillWord,
  input  ctrl_strb_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  output logic [SLOTS-1:0]  validVec,
  output logic [SLOTS-1:0]  matchVec,
  output logic              hitAny,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [7:0]        rdByte
);
  logic [TAG_W-1:0]  tagMem  [SLOTS];
  logic [WORD_W-1:0] dataMem [SLOTS];
  logic [TAG_W-1:0]  reqTag;
  logic [OFFS_W-1:0] reqOffs;
  logic [WORD_W-1:0] selWord;

  assign reqTag  = reqAddr[ADDR_W-1:OFFS_W];
  assign reqOffs = reqAddr[OFFS_W-1:0];

  // Valid flags: reset and flush clear, writes set
  always_ff @(posedge clk) begin
    if (!rstN || strb.flushAll) validVec <= '0;
    else if (strb.wrEn)         validVec[wrIdx] <= 1'b1;
  end

  // Tag and data storage
  always_ff @(posedge clk) begin
    if (strb.wrEn && !strb.flushAll) begin
      tagMem[wrIdx]  <= reqTag;
      dataMem[wrIdx] <= refillWord;
    end
  end

  // Parallel compare against every valid tag
  for (genvar g = 0; g < SLOTS; g++) begin : gCmp
    assign matchVec[g] = validVec[g] && (tagMem[g] == reqTag);
  end

  assign hitAny = |matchVec;

  // Lowest matching slot (at most one matches on a correct design)
  always_comb begin
    hitIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign selWord = dataMem[hitIdx];
  assign rdByte  = hitAny ? selWord[8*reqOffs +: 8] : 8'h00;

  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (validVec == '0));
  assert_single_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
endmodule

// File: rtl/tgt_cache_ctrl.sv
`timescale 1ns/1ps
module tgt_cache_ctrl
  import tgt_cache_pkg::*;
#(
  parameter int SLOTS = 63,
  localparam int IDX_W = $clog2(SLOTS),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refillValid,
  input  logic             cacheEn,
  input  logic             flush,
  input  logic [SLOTS-1:0] validVec,
  input  logic             hitAny,
  input  logic [IDX_W-1:0] hitIdx,
  output ctrl_strb_t       strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic             refillAck
);
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] freeIdx;
  logic             anyFree;
  logic             alloc;

  // Lowest empty slot
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  always_comb begin
    strb.flushAll = flush;
    strb.wrEn     = refillValid && cacheEn && !flush;
    alloc         = strb.wrEn && !hitAny;
    if (hitAny)       wrIdx = hitIdx;
    else if (anyFree) wrIdx = freeIdx;
    else              wrIdx = ptr;
  end

  // Round-robin pointer advances on each new allocation
  always_ff @(posedge clk) begin
    if (!rstN || flush)  ptr <= '0;
    else if (alloc)      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) refillAck <= 1'b0;
    else       refillAck <= refillValid;
  end

  assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST);
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (alloc && ptr == LAST) |=> (ptr == '0));
  assert_refill_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    refillValid |=> refillAck);
endmodule

// File: rtl/tgt_cache.sv
`timescale 1ns/1ps
module tgt_cache
  import tgt_cache_pkg::*;
#(
  parameter int SLOTS  = 63,
  parameter int ADDR_W = 17,
  parameter int BYTES  = 4,
  localparam int WORD_W = 8 * BYTES,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cacheEn,
  input  logic              flush,
  input  logic              refillValid,
  input  logic [WORD_W-1:0] refillWord,
  output logic              hit,
  output logic              miss,
  output logic [7:0]        rdByte,
  output logic              refillAck
);
  ctrl_strb_t       strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] hitIdx;
  logic [SLOTS-1:0] validVec;
  logic [SLOTS-1:0] matchVec;
  logic             hitAny;
  logic [7:0]       dpByte;

  tgt_cache_dp #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .BYTES(BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .refillWord(refillWord),
    .strb(strb), .wrIdx(wrIdx), .validVec(validVec), .matchVec(matchVec),
    .hitAny(hitAny), .hitIdx(hitIdx), .rdByte(dpByte)
  );

  tgt_cache_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .refillValid(refillValid), .cacheEn(cacheEn),
    .flush(flush), .validVec(validVec), .hitAny(hitAny), .hitIdx(hitIdx),
    .strb(strb), .wrIdx(wrIdx), .refillAck(refillAck)
  );

  assign hit    = reqValid && hitAny;
  assign miss   = reqValid && !hitAny;
  assign rdByte = hit ? dpByte : 8'h00;

  assert_no_fill_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cacheEn |=> ((validVec & ~$past(validVec)) == '0));
  assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && miss));
endmodule

// File: tb/tgt_cache_bench.sv
`timescale 1ns/1ps
module tgt_cache_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [16:0] reqAddr = '0;
  logic        cacheEn = 1'b1;
  logic        flush = 1'b0;
  logic        refillValid = 1'b0;
  logic [31:0] refillWord = '0;
  logic        hit, miss, refillAck;
  logic [7:0]  rdByte;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  tgt_cache u_tgt_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .cacheEn(cacheEn), .flush(flush), .refillValid(refillValid),
    .refillWord(refillWord), .hit(hit), .miss(miss), .rdByte(rdByte),
    .refillAck(refillAck)
  );

  function automatic logic [31:0] wordOf(int k);
    return 32'h1F2E3D4C ^ (k * 32'h01030507);
  endfunction

  function automatic logic [16:0] blkAddr(int k);
    return 17'(32'h08000 + k * 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present a request; outputs sampled away from the clock edge
  task automatic look(input logic [16:0] a);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    #1;
  endtask

  task automatic expectHit(input logic [16:0] a, input logic [31:0] w, input string tag);
    look(a);
    chk(hit === 1'b1 && miss === 1'b0, tag, {hit, miss}, 2'b10);
    chk(rdByte === w[8*a[1:0] +: 8], tag, rdByte, w[8*a[1:0] +: 8]);
  endtask

  task automatic expectMiss(input logic [16:0] a, input string tag);
    look(a);
    chk(hit === 1'b0 && miss === 1'b1 && rdByte === 8'h00, tag,
        {hit, miss, rdByte}, 10'h100);
  endtask

  task automatic refill(input logic [16:0] a, input logic [31:0] w, input logic en,
                        input logic fl);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = a;
    refillWord = w;
    cacheEn = en;
    flush = fl;
    refillValid = 1'b1;
    @(negedge clk);
    refillValid = 1'b0;
    flush = 1'b0;
    cacheEn = 1'b1;
    chk(refillAck === 1'b1, "R4 refillAck", refillAck, 1);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    expectMiss(17'h00000, "R1 reset empty addr0");
    expectMiss(17'h1FFFF, "R1 reset empty top addr");
    chk(refillAck === 1'b0, "R1 ack idle after reset", refillAck, 0);
  endtask

  task automatic t_fill_read();
    refill(17'h00101, 32'hDDCCBBAA, 1'b1, 1'b0);
    expectHit(17'h00100, 32'hDDCCBBAA, "R2 byte0");
    expectHit(17'h00101, 32'hDDCCBBAA, "R2 byte1");
    expectHit(17'h00102, 32'hDDCCBBAA, "R2 byte2");
    expectHit(17'h00103, 32'hDDCCBBAA, "R4 byte3 after refill");
    expectMiss(17'h00104, "R3 next block misses");
    expectMiss(17'h10100, "R3 upper tag bit differs");
  endtask

  task automatic t_disabled();
    refill(17'h00200, 32'h11223344, 1'b0, 1'b0);
    expectMiss(17'h00200, "R5 disabled refill not stored");
    expectHit(17'h00102, 32'hDDCCBBAA, "R5 existing slot kept");
  endtask

  task automatic t_flush();
    doFlush();
    expectMiss(17'h00100, "R8 flushed block misses");
    refill(17'h00300, 32'h55667788, 1'b1, 1'b1);
    expectMiss(17'h00300, "R8 refill during flush dropped");
  endtask

  task automatic t_dup();
    doFlush();
    refill(17'h00400, 32'hA0A1A2A3, 1'b1, 1'b0);
    refill(17'h00402, 32'hB0B1B2B3, 1'b1, 1'b0);
    expectHit(17'h00400, 32'hB0B1B2B3, "R9 duplicate rewritten byte0");
    expectHit(17'h00403, 32'hB0B1B2B3, "R9 duplicate rewritten byte3");
  endtask

  task automatic t_fill_all();
    doFlush();
    for (int k = 0; k < 63; k++) refill(blkAddr(k), wordOf(k), 1'b1, 1'b0);
    for (int k = 0; k < 63; k++)
      expectHit(blkAddr(k) + 17'(k % 4), wordOf(k), "R6 all 63 resident");
    // cache full: pointer wrapped to 0, oldest block goes first
    refill(blkAddr(63), wordOf(63), 1'b1, 1'b0);
    expectMiss(blkAddr(0), "R7 slot0 block evicted");
    expectHit(blkAddr(1), wordOf(1), "R7 slot1 block kept");
    expectHit(blkAddr(63), wordOf(63), "R7 new block resident");
    refill(blkAddr(64), wordOf(64), 1'b1, 1'b0);
    expectMiss(blkAddr(1), "R7 slot1 block evicted next");
    expectHit(blkAddr(2) + 17'd2, wordOf(2), "R7 slot2 block kept");
    expectHit(blkAddr(63), wordOf(63), "R7 previous insert kept");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fill_read();
    t_disabled();
    t_flush();
    t_dup();
    t_fill_all();
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule